// File: doc/BRIEF.md
# Glitch-Free System Clock Source Selector

This block derives three system clocks (auxiliary, main and subsystem), a divided copy of the digitally controlled oscillator (DCO), and an externally visible copy of the auxiliary clock. Each system clock has a 3-bit source code, which picks one of six sources, and a 3-bit power-of-two divider. The six sources are a low-frequency crystal, a very-low-power internal oscillator, an internal 32.768 kHz reference, the DCO, the divided DCO and a high-frequency crystal. The crystal codes fall back to other sources while the crystal is reported invalid. A gate bit can stop the subsystem clock. The oscillators themselves are outside the block. Their outputs and validity flags arrive as inputs.

The block works in a single fast sampling domain `clk`. Every source clock is a level signal that is synchronous to `clk` and slower than it. Every produced clock is a registered level in the same domain. In this domain, "glitch-free" has a concrete meaning: no high or low phase of an output is ever shorter than the matching phase of the source it runs from. There are two rules that keep it so:
- When the source changes, the old source is released in its low phase. After a two-stage handshake, the new source is armed in its own low phase.
- A new divider code is adopted only at the divider's terminal count.

Source codes are captured on a load strobe. Divider codes and the gate bit are used directly.

Top module: `clock_src_sel`

## Requirements
- R1: Source code 000 selects the low-frequency crystal, 001 selects the very-low-power oscillator, 010 selects the internal reference, 011 selects the DCO and 100 selects the divided DCO.
- R2: Source code 101 selects the high-frequency crystal while `hf_ok` is 1. While `hf_ok` is 0, it selects the divided DCO.
- R3: The reserved source codes 110 and 111 select the divided DCO.
- R4: A system clock divider code c divides by 2^c for c = 0..5 (000=/1 up to 101=/32). Codes 110 and 111 divide by 32. At ratio N, the output period is N source periods, with N/2 of them high.
- R5: `dcodiv_clk` is the DCO divided using the same encoding, set by `dcodiv_code`.
- R6: `aux_pin_clk` is the auxiliary clock divided again using the same encoding, set by `aux_pin_div`.
- R7: While reset is asserted, all outputs are low. After reset, the main and subsystem clocks run from the divided DCO and the auxiliary clock uses code 000.
- R8: While `lf_ok` is 0, code 000 selects the internal reference if `lf_lowfreq` is 1, and the DCO otherwise.
- R9: While `sub_off` is 1, `sub_clk` stays low. When `sub_off` returns to 0, `sub_clk` resumes. The gate changes only while the divided subsystem clock is low.
- R10: A source change never produces an output phase shorter than the shorter half-period of the old and new sources.
- R11: A divider code change takes effect only at the terminal count. No output phase is shorter than the shorter half-period of the old and new ratios.
- R12: Changes on `aux_sel`, `main_sel` and `sub_sel` have no effect until `sel_load` is 1 at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lf_clk | input | 1 | Low-frequency crystal level |
| lf_ok | input | 1 | Low-frequency crystal valid |
| lf_lowfreq | input | 1 | Low-frequency crystal in low-frequency mode |
| vlo_clk | input | 1 | Very-low-power oscillator level |
| ref_clk | input | 1 | Internal reference level |
| dco_clk | input | 1 | DCO level |
| hf_clk | input | 1 | High-frequency crystal level |
| hf_ok | input | 1 | High-frequency crystal valid |
| dcodiv_code | input | 3 | Divided-DCO ratio code |
| sel_load | input | 1 | Capture the three source codes |
| aux_sel | input | 3 | Auxiliary source code |
| main_sel | input | 3 | Main source code |
| sub_sel | input | 3 | Subsystem source code |
| aux_div | input | 3 | Auxiliary divider code |
| main_div | input | 3 | Main divider code |
| sub_div | input | 3 | Subsystem divider code |
| aux_pin_div | input | 3 | External auxiliary copy divider code |
| sub_off | input | 1 | 1 stops the subsystem clock |
| dcodiv_clk | output | 1 | Divided DCO |
| aux_clk | output | 1 | Auxiliary clock |
| main_clk | output | 1 | Main clock |
| sub_clk | output | 1 | Subsystem clock |
| aux_pin_clk | output | 1 | External copy of the auxiliary clock |

## Verification
The hardest situation to reach from the ports is a source switch or a divider change that arrives part-way through a high phase or a count. Only then can a runt pulse or a shortened period appear. The bench drives the five sources with periods of 32, 40, 24, 4 and 6 cycles, so switch requests land at many different phases. It chains several switches back to back and changes a divider from /8 to /2 mid-count. A monitor records the shortest high or low phase of every output over each window and compares it with the shortest legal half-period.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
  localparam int SEL_W     = 3;
  localparam int NSRC      = 6;
  localparam int IDX_W     = $clog2(NSRC);
  localparam int NCHAN     = 3;
  localparam int MAX_SHIFT = 5;
  localparam int CNT_W     = MAX_SHIFT;

  localparam logic [IDX_W-1:0] SRC_LF   = 3'd0;
  localparam logic [IDX_W-1:0] SRC_VLO  = 3'd1;
  localparam logic [IDX_W-1:0] SRC_REF  = 3'd2;
  localparam logic [IDX_W-1:0] SRC_DCO  = 3'd3;
  localparam logic [IDX_W-1:0] SRC_DDIV = 3'd4;
  localparam logic [IDX_W-1:0] SRC_HF   = 3'd5;

  // Map a source code plus oscillator health to a source index
  function automatic logic [IDX_W-1:0] resolve_src(input logic [SEL_W-1:0] code,
                                                   input logic lf_ok, input logic hf_ok,
                                                   input logic lf_low);
    case (code)
      3'b000:  return lf_ok ? SRC_LF : (lf_low ? SRC_REF : SRC_DCO);
      3'b001:  return SRC_VLO;
      3'b010:  return SRC_REF;
      3'b011:  return SRC_DCO;
      3'b101:  return hf_ok ? SRC_HF : SRC_DDIV;
      default: return SRC_DDIV;
    endcase
  endfunction

  // log2 of the ratio; codes above the largest shift saturate
  function automatic logic [SEL_W-1:0] div_shift(input logic [SEL_W-1:0] code);
    return (code > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : code;
  endfunction

  // terminal count value (ratio - 1)
  function automatic logic [CNT_W-1:0] div_last(input logic [SEL_W-1:0] code);
    logic [CNT_W:0] full;
    full = (CNT_W+1)'(1) << div_shift(code);
    return CNT_W'(full - (CNT_W+1)'(1));
  endfunction

  // count at which the output drops (ratio/2 - 1)
  function automatic logic [CNT_W-1:0] div_half_m1(input logic [SEL_W-1:0] code);
    logic [CNT_W:0] full;
    full = (CNT_W+1)'(1) << div_shift(code);
    return CNT_W'((full >> 1) - (CNT_W+1)'(1));
  endfunction
endpackage

// File: rtl/clk_div_stage.sv
module clk_div_stage
  import clk_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_i,
  input  logic [SEL_W-1:0] code_i,
  output logic             clk_o
);
  logic             src_d;
  logic [SEL_W-1:0] act_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_w;
  logic [CNT_W-1:0] halfm1_w;
  logic             pass_w;
  logic             rise_w;
  logic             term_w;

  assign last_w   = div_last(act_q);
  assign halfm1_w = div_half_m1(act_q);
  assign pass_w   = (div_shift(act_q) == '0);
  assign rise_w   = src_i & ~src_d;
  assign term_w   = rise_w && (cnt_q == last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_d <= 1'b0;
      act_q <= '0;
      cnt_q <= '0;
      clk_o <= 1'b0;
    end else begin
      src_d <= src_i;
      if (term_w) begin
        cnt_q <= '0;
        act_q <= code_i;
        clk_o <= 1'b1;
      end else if (rise_w) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == halfm1_w) clk_o <= 1'b0;
      end else if (pass_w) begin
        clk_o <= src_i;
      end
    end
  end

  // R11
  act_at_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(term_w));
  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_w);
  // R10
  rise_on_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_o) |-> $past(rise_w));
endmodule

// File: rtl/glitchfree_mux.sv
module glitchfree_mux
  import clk_sel_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int W     = IDX_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [W-1:0]     req_i,
  output logic             clk_o
);
  typedef enum logic [1:0] {SW_RUN, SW_SYNC1, SW_SYNC2, SW_ARM} sw_state_e;

  sw_state_e   st_q;
  logic [W-1:0] cur_q;
  logic         en_q;
  logic         cur_lvl_w;
  logic         swap_w;

  assign cur_lvl_w = src_i[cur_q];
  assign swap_w    = (st_q == SW_RUN) && (req_i != cur_q) && !cur_lvl_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SW_SYNC1;
      cur_q <= '0;
      en_q  <= 1'b0;
      clk_o <= 1'b0;
    end else begin
      clk_o <= en_q & cur_lvl_w;
      case (st_q)
        SW_RUN: if (swap_w) begin
          en_q <= 1'b0;
          st_q <= SW_SYNC1;
        end
        SW_SYNC1: st_q <= SW_SYNC2;
        SW_SYNC2: begin
          cur_q <= req_i;
          st_q  <= SW_ARM;
        end
        default: if (!cur_lvl_w) begin
          en_q <= 1'b1;
          st_q <= SW_RUN;
        end
      endcase
    end
  end

  // R10
  release_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> !clk_o);
  // R10
  cur_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_q) |-> (!en_q && !$past(en_q)));
endmodule

// File: rtl/clock_src_sel.sv
module clock_src_sel
  import clk_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lf_clk,
  input  logic             lf_ok,
  input  logic             lf_lowfreq,
  input  logic             vlo_clk,
  input  logic             ref_clk,
  input  logic             dco_clk,
  input  logic             hf_clk,
  input  logic             hf_ok,
  input  logic [SEL_W-1:0] dcodiv_code,
  input  logic             sel_load,
  input  logic [SEL_W-1:0] aux_sel,
  input  logic [SEL_W-1:0] main_sel,
  input  logic [SEL_W-1:0] sub_sel,
  input  logic [SEL_W-1:0] aux_div,
  input  logic [SEL_W-1:0] main_div,
  input  logic [SEL_W-1:0] sub_div,
  input  logic [SEL_W-1:0] aux_pin_div,
  input  logic             sub_off,
  output logic             dcodiv_clk,
  output logic             aux_clk,
  output logic             main_clk,
  output logic             sub_clk,
  output logic             aux_pin_clk
);
  localparam logic [NCHAN-1:0][SEL_W-1:0] SEL_RST = {3'b100, 3'b100, 3'b000};

  logic [NCHAN-1:0][SEL_W-1:0] sel_q;
  logic [NCHAN-1:0][SEL_W-1:0] sel_in_w;
  logic [NCHAN-1:0][SEL_W-1:0] div_in_w;
  logic [NCHAN-1:0]            sys_w;
  logic [NSRC-1:0]             src_w;
  logic                        ddiv_w;
  logic                        gate_q;

  assign sel_in_w = {sub_sel, main_sel, aux_sel};
  assign div_in_w = {sub_div, main_div, aux_div};
  assign src_w    = {hf_clk, ddiv_w, dco_clk, ref_clk, vlo_clk, lf_clk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_q <= SEL_RST;
    else if (sel_load) sel_q <= sel_in_w;
  end

  clk_div_stage u_ddiv (
    .clk(clk), .rst_n(rst_n), .src_i(dco_clk), .code_i(dcodiv_code), .clk_o(ddiv_w)
  );

  for (genvar g = 0; g < NCHAN; g++) begin : g_chan
    logic [IDX_W-1:0] req_w;
    logic             mux_w;
    assign req_w = resolve_src(sel_q[g], lf_ok, hf_ok, lf_lowfreq);
    glitchfree_mux u_mux (
      .clk(clk), .rst_n(rst_n), .src_i(src_w), .req_i(req_w), .clk_o(mux_w)
    );
    clk_div_stage u_div (
      .clk(clk), .rst_n(rst_n), .src_i(mux_w), .code_i(div_in_w[g]), .clk_o(sys_w[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gate_q <= 1'b0;
    else if (!sys_w[2]) gate_q <= ~sub_off;
  end

  clk_div_stage u_pin (
    .clk(clk), .rst_n(rst_n), .src_i(sys_w[0]), .code_i(aux_pin_div), .clk_o(aux_pin_clk)
  );

  assign dcodiv_clk = ddiv_w;
  assign aux_clk    = sys_w[0];
  assign main_clk   = sys_w[1];
  assign sub_clk    = gate_q & sys_w[2];

  // R12
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(sel_load));
  // R9
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_q) |-> !$past(sys_w[2]));
  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sub_off) && !$past(sys_w[2])) |=> !sub_clk);
endmodule

// File: tb/tb_clock_src_sel.sv
module tb_clock_src_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NOUT = 5;
  localparam int LIM  = 6000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lf_clk = 0, vlo_clk = 0, ref_clk = 0, dco_clk = 0, hf_clk = 0;
  logic lf_ok = 1, hf_ok = 1, lf_lowfreq = 1, sel_load = 0, sub_off = 0;
  logic [2:0] dcodiv_code = 3'd1, aux_sel = 0, main_sel = 0, sub_sel = 0;
  logic [2:0] aux_div = 0, main_div = 0, sub_div = 0, aux_pin_div = 3'd2;
  logic dcodiv_clk, aux_clk, main_clk, sub_clk, aux_pin_clk;

  clock_src_sel dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // channels: 0 dcodiv, 1 aux, 2 main, 3 sub, 4 aux pin
  logic [NOUT-1:0] outs, prev = '0;
  assign outs = {aux_pin_clk, sub_clk, main_clk, aux_clk, dcodiv_clk};

  int cyc = 0, errors = 0, checks = 0;
  int wid[NOUT], minw[NOUT], rises[NOUT];
  bit skip[NOUT];

  // sources: periods lf 32, vlo 40, ref 24, dco 4, hf 6 cycles
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      n++;
      lf_clk = (n % 32) < 16; vlo_clk = (n % 40) < 20; ref_clk = (n % 24) < 12;
      dco_clk = (n % 4) < 2;  hf_clk = (n % 6) < 3;
    end
  end

  // phase-width monitor
  initial begin
    for (int c = 0; c < NOUT; c++) begin wid[c] = 0; minw[c] = 99999; rises[c] = 0; skip[c] = 1; end
    forever begin
      @(negedge clk);
      cyc++;
      for (int c = 0; c < NOUT; c++) begin
        if (outs[c] == prev[c]) wid[c]++;
        else begin
          if (!skip[c] && wid[c] < minw[c]) minw[c] = wid[c];
          skip[c] = 0; wid[c] = 1;
          if (outs[c]) rises[c]++;
        end
      end
      prev = outs;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ratio(input int code);
    return (code >= 5) ? 32 : (1 << code);
  endfunction

  // scoreboard
  typedef struct { int ch; int exp; string tag; } item_t;
  item_t sbq[$];
  bit busy = 0;

  task automatic measure(input int ch, output int per);
    int r0, t1, lim;
    per = 0; r0 = rises[ch]; lim = 0;
    while (rises[ch] < r0 + 2 && lim < LIM) begin @(negedge clk); #1; lim++; end
    t1 = cyc;
    while (rises[ch] < r0 + 3 && lim < LIM) begin @(negedge clk); #1; lim++; end
    if (lim < LIM) per = cyc - t1;
  endtask

  initial begin
    item_t it;
    int per;
    forever begin
      wait (sbq.size() > 0);
      busy = 1;
      it = sbq.pop_front();
      measure(it.ch, per);
      chk(per == it.exp, it.tag, per, it.exp);
      busy = 0;
    end
  end

  task automatic expect_period(input int ch, input int exp, input string tag);
    item_t it;
    it.ch = ch; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    #1;
    wait (sbq.size() == 0 && !busy);
  endtask

  task automatic load_sel();
    @(negedge clk); sel_load = 1; @(negedge clk); sel_load = 0;
  endtask

  task automatic clear_stats(input int ch);
    minw[ch] = 99999; skip[ch] = 1;
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int r0;
    wait_cyc(5);
    chk(outs == '0, "R7 outputs low in reset", int'(outs), 0);
    rst_n = 1;
    // R7 defaults: aux on lf (32), main/sub on divided DCO (/2 -> 8)
    wait_cyc(200);
    expect_period(1, 32, "R7 aux default lf");
    expect_period(2, 4 * ratio(1), "R7 main default dcodiv");
    expect_period(3, 8, "R7 sub default dcodiv");
    // R5
    expect_period(0, 8, "R5 dcodiv /2");
    dcodiv_code = 3'd3; wait_cyc(100);
    expect_period(0, 32, "R5 dcodiv /8");
    dcodiv_code = 3'd0; wait_cyc(100);
    expect_period(0, 4, "R5 dcodiv /1");
    dcodiv_code = 3'd1; wait_cyc(100);
    // R6
    expect_period(4, 32 * ratio(2), "R6 pin /4");
    aux_pin_div = 3'd1; wait_cyc(300);
    expect_period(4, 64, "R6 pin /2");
    // R1
    aux_sel = 0; sub_sel = 3'b100;
    main_sel = 3'b000; load_sel(); wait_cyc(150); expect_period(2, 32, "R1 code 000 lf");
    main_sel = 3'b001; load_sel(); wait_cyc(150); expect_period(2, 40, "R1 code 001 vlo");
    main_sel = 3'b010; load_sel(); wait_cyc(150); expect_period(2, 24, "R1 code 010 ref");
    main_sel = 3'b011; load_sel(); wait_cyc(150); expect_period(2, 4,  "R1 code 011 dco");
    main_sel = 3'b100; load_sel(); wait_cyc(150); expect_period(2, 8,  "R1 code 100 dcodiv");
    // R12: no load, no change
    main_sel = 3'b001; wait_cyc(150);
    expect_period(2, 8, "R12 select ignored without load");
    // R2
    main_sel = 3'b101; load_sel(); wait_cyc(150); expect_period(2, 6, "R2 hf valid");
    hf_ok = 0; wait_cyc(150); expect_period(2, 8, "R2 hf invalid fallback");
    hf_ok = 1;
    // R3
    main_sel = 3'b110; load_sel(); wait_cyc(150); expect_period(2, 8, "R3 code 110");
    main_sel = 3'b111; load_sel(); wait_cyc(150); expect_period(2, 8, "R3 code 111");
    // R4 on DCO
    main_sel = 3'b011; load_sel(); wait_cyc(150);
    main_div = 3'd3; wait_cyc(150); expect_period(2, 32,  "R4 div /8");
    main_div = 3'd6; wait_cyc(200); expect_period(2, 128, "R4 div code 110 /32");
    main_div = 3'd5; wait_cyc(200); expect_period(2, 128, "R4 div /32");
    main_div = 3'd3; wait_cyc(300);
    // R11: /8 -> /2 mid-count, shortest phase must be >= 4
    clear_stats(2);
    main_div = 3'd1; wait_cyc(300);
    chk(minw[2] >= 4, "R11 no shortened phase on divider change", minw[2], 4);
    expect_period(2, 8, "R11 new ratio /2");
    // R10: chained source switches at /1, shortest half-period 2
    main_div = 3'd0; wait_cyc(100);
    clear_stats(2);
    main_sel = 3'b001; load_sel(); wait_cyc(170);
    main_sel = 3'b101; load_sel(); wait_cyc(130);
    main_sel = 3'b011; load_sel(); wait_cyc(110);
    main_sel = 3'b010; load_sel(); wait_cyc(90);
    main_sel = 3'b011; load_sel(); wait_cyc(100);
    chk(minw[2] >= 2, "R10 no runt phase on source switch", minw[2], 2);
    expect_period(2, 4, "R10 final source dco");
    // R9
    clear_stats(3);
    sub_off = 1; wait_cyc(50);
    r0 = rises[3];
    wait_cyc(300);
    chk(rises[3] == r0, "R9 sub stopped no rises", rises[3] - r0, 0);
    chk(sub_clk == 1'b0, "R9 sub held low", int'(sub_clk), 0);
    sub_off = 0; wait_cyc(50);
    expect_period(3, 8, "R9 sub resumes");
    chk(minw[3] >= 4, "R9 gate no runt", minw[3], 4);
    // R8 on aux code 000
    lf_ok = 0; lf_lowfreq = 1; wait_cyc(200);
    expect_period(1, 24, "R8 lf invalid lowfreq -> ref");
    lf_lowfreq = 0; wait_cyc(200);
    expect_period(1, 4, "R8 lf invalid other -> dco");
    lf_ok = 1; wait_cyc(200);
    expect_period(1, 32, "R8 lf valid again");
    summary();
    $finish;
  end
endmodule